// File: doc/BRIEF.md
# Programmable 16x Baud Divider

This block produces the sixteen-times-oversampling clock enable that the transmitter and receiver of a UART run on. A reference clock is divided by a 16-bit divisor. The divisor is stored as two byte-wide latches on a small byte-wide register bus. The output `tick16` is a one-cycle pulse that repeats once per divisor period. The serial rate is therefore the reference frequency divided by sixteen times the divisor.

The latches share the bus addresses used by the data buffers and the interrupt-enable register. The most significant bit of the line control register selects which of them is reached. That bit is called the access bit below, and the line control register lives in this block at address 3. When the access bit is 0, accesses to addresses 0 and 1 are flagged on `pass_sel` so that neighbouring logic can service them.

Writing either divisor byte reloads the counter at once. A new rate therefore never has to wait out a stale long count.

The counter is a two-state machine:
- **ST_HALT**: no ticks are produced.
- **ST_COUNT**: a down-counter runs from the divisor to 1. The tick is asserted in the cycle where the count equals 1, and the counter then reloads.

Its transitions are:
- **HALT→COUNT (load)**: a nonzero divisor is written.
- **COUNT→COUNT (wrap)**: the count reaches 1 and the counter reloads from the latches.
- **COUNT→COUNT (reload)**: a divisor byte is written while counting.
- **COUNT→HALT (zero load)**: a divisor of 0 is written.
- **any→HALT (reset)**: master reset.

Top module: `baud16_gen`

## Requirements
- R1: With the access bit (bit 7 of the line control register at address 3) set, address 0 reads and writes the low divisor byte and address 1 the high divisor byte. Reads return the stored bytes unchanged.
- R2: With the access bit clear, an access to address 0 or 1 leaves both divisor bytes and the counter untouched. Such an access asserts `pass_sel` and reads 0 on `bus_rdata`.
- R3: The line control register is fully readable and writable at address 3 in either access state. Its bits 6:0 appear on `line_fmt`.
- R4: A write to either divisor byte reloads the counter with the complete new divisor on that clock edge. With divisor D, the first tick is high in the D-th cycle after the write edge, whatever the old count was.
- R5: For a steady divisor D from 1 to 65535, `tick16` is high for exactly one cycle in every D cycles. A divisor of 1 gives a tick in every cycle.
- R6: A divisor of 0 stops the ticks. No tick is produced until a nonzero divisor is written.
- R7: Master reset (`rst`, synchronous, active high) has four effects:
  - it clears the line control register, including the access bit;
  - it keeps both divisor bytes;
  - it holds `tick16` low;
  - ticks stay off until the next divisor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, synchronous, active high |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pass_sel | output | 1 | Access at address 0/1 belongs to the neighbouring registers |
| line_fmt | output | 7 | Line control bits 6:0 for the serial logic |
| tick16 | output | 1 | One-cycle 16x clock enable |

## Verification
The bench builds the block with its defaults:
- byte width 8;
- divisor width 16;
- `ZERO_HALTS` = 1, so a zero divisor stops the ticks.

Two-byte divisors up to 259 exercise the carry across the byte boundary. Random small divisors keep many complete periods inside the run. A rewrite in the middle of a count shows that the reload takes effect at once. The zero case and a reset in the middle of a run show that the latches outlive reset while the ticks do not.

// File: rtl/baud16_pkg.sv
package baud16_pkg;

    typedef enum logic [0:0] {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_t;

    localparam int ADDR_LCR = 3;

endpackage

// File: rtl/b16_regif.sv
module b16_regif
    import baud16_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int DIV_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [DIV_W-1:0]  div_q,
    output logic [NBYTES-1:0] byte_we,
    output logic [BYTE_W-1:0] lcr_q,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              pass_sel
);

    logic access_on;
    logic lcr_hit;

    assign access_on = lcr_q[BYTE_W-1];
    assign lcr_hit   = bus_sel && (bus_addr == ADDR_W'(ADDR_LCR));

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q <= '0;
        end else if (lcr_hit && bus_wr) begin
            lcr_q <= bus_wdata;
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_we
        assign byte_we[i] = bus_sel && bus_wr && access_on
                            && (bus_addr == ADDR_W'(i));
    end

    assign pass_sel = bus_sel && (bus_wr || bus_rd) && !access_on
                      && (bus_addr < ADDR_W'(NBYTES));

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && bus_rd) begin
            if (lcr_hit) begin
                bus_rdata = lcr_q;
            end
            for (int i = 0; i < NBYTES; i++) begin
                if (access_on && (bus_addr == ADDR_W'(i))) begin
                    bus_rdata = div_q[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    AST_RESET_CLEARS_LCR: assert property (@(posedge clk) rst |=> (lcr_q == '0)); // R7
    AST_GATED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !lcr_q[BYTE_W-1]) |-> (byte_we == '0)); // R2

endmodule

// File: rtl/b16_latch.sv
module b16_latch #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int DIV_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBYTES-1:0] byte_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_next,
    output logic              load
);

    assign load = |byte_we;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (byte_we[i]) begin
                div_q[i*BYTE_W +: BYTE_W] <= wdata;
            end
        end
        assign div_next[i*BYTE_W +: BYTE_W] = byte_we[i] ? wdata
                                                         : div_q[i*BYTE_W +: BYTE_W];
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(div_q)); // R2
    AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (rst)
        $countones(byte_we) <= 1); // R1

endmodule

// File: rtl/b16_counter.sv
module b16_counter
    import baud16_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter bit ZERO_HALTS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_next,
    input  logic [DIV_W-1:0] div_q,
    output logic             tick
);

    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    cnt_state_t       state, state_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic             zero_runs;

    if (ZERO_HALTS) begin : g_zero_halt
        assign zero_runs = 1'b0;
    end else begin : g_zero_wrap
        assign zero_runs = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HALT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_HALT: begin
                if (load && ((div_next != '0) || zero_runs)) begin
                    state_n = ST_COUNT;
                    cnt_n   = div_next;
                end
            end
            ST_COUNT: begin
                if (load) begin
                    if ((div_next != '0) || zero_runs) begin
                        cnt_n = div_next;
                    end else begin
                        state_n = ST_HALT;
                        cnt_n   = '0;
                    end
                end else if (cnt == CNT_ONE) begin
                    cnt_n = div_q;
                end else begin
                    cnt_n = cnt - CNT_ONE;
                end
            end
            default: begin
                state_n = ST_HALT;
            end
        endcase
    end

    always_comb begin
        tick = (state == ST_COUNT) && (cnt == CNT_ONE);
    end

    AST_LOAD_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (load && (div_next != '0)) |=> (cnt == $past(div_next))); // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (cnt == $past(div_q))); // R5
    AST_RESET_SILENT: assert property (@(posedge clk) rst |=> !tick); // R7

    if (ZERO_HALTS) begin : g_zero_chk
        AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
            (load && (div_next == '0)) |=> !tick); // R6
        AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
            (state == ST_COUNT) |-> (cnt != '0)); // R6
    end

endmodule

// File: rtl/baud16_gen.sv
module baud16_gen #(
    parameter int ADDR_W     = 3,
    parameter int BYTE_W     = 8,
    parameter int DIV_W      = 16,
    parameter bit ZERO_HALTS = 1'b1,
    localparam int NBYTES    = DIV_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              pass_sel,
    output logic [BYTE_W-2:0] line_fmt,
    output logic              tick16
);

    logic [NBYTES-1:0] byte_we;
    logic [BYTE_W-1:0] lcr_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_next;
    logic              load;

    b16_regif #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .div_q     (div_q),
        .byte_we   (byte_we),
        .lcr_q     (lcr_q),
        .bus_rdata (bus_rdata),
        .pass_sel  (pass_sel)
    );

    b16_latch #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .byte_we  (byte_we),
        .wdata    (bus_wdata),
        .div_q    (div_q),
        .div_next (div_next),
        .load     (load)
    );

    b16_counter #(.DIV_W(DIV_W), .ZERO_HALTS(ZERO_HALTS)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .div_next (div_next),
        .div_q    (div_q),
        .tick     (tick16)
    );

    assign line_fmt = lcr_q[BYTE_W-2:0];

endmodule

// File: tb/baud16_gen_bench.sv
module baud16_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pass_sel;
    logic [6:0] line_fmt;
    logic       tick16;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_lo = '0, m_hi = '0, m_lcr = '0;
    bit   m_run = 0;
    int   since = 0;
    bit   mon_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud16_gen u_baud16_gen (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pass_sel(pass_sel), .line_fmt(line_fmt), .tick16(tick16)
    );

    function automatic int cur_div();
        return {16'd0, m_hi, m_lo};
    endfunction

    function automatic bit exp_tick(int d, int n, bit run);
        if (!run || d == 0) return 1'b0;
        return (n % d) == (d - 1);
    endfunction

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle tick comparison
    always @(negedge clk) begin
        if (mon_on) begin
            string tag;
            if (!m_run) tag = (cur_div() == 0) ? "R6" : "R7";
            else if (since < cur_div()) tag = "R4";
            else tag = "R5";
            chk(tag, int'(tick16), int'(exp_tick(cur_div(), since, m_run)));
            since++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        m_lcr = '0;
        m_run = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        #1;
        chk("R2", int'(pass_sel), int'(!m_lcr[7] && a < 3'd2));
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0;
        if (a == 3'd3) m_lcr = d;
        else if (m_lcr[7] && a < 3'd2) begin
            if (a == 3'd0) m_lo = d; else m_hi = d;
            since = 0;
            m_run = (cur_div() != 0);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), int'(exp));
        @(posedge clk);
        #1;
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1A2B);
        repeat (3) @(posedge clk);
        #1;
        mon_on = 1;
        @(negedge clk);
        rst = 1'b0;
        // reset state
        rd(3'd3, 8'h00, "R7");
        chk("R3", int'(line_fmt), 0);
        wr(3'd3, 8'h80);
        rd(3'd3, 8'h80, "R3");
        // single byte divisor
        wr(3'd0, 8'd5);
        wr(3'd1, 8'd0);
        run(20);
        rd(3'd0, 8'd5, "R1");
        rd(3'd1, 8'd0, "R1");
        // divisor one: tick every cycle
        wr(3'd0, 8'd1);
        run(8);
        // two-byte divisor 259
        wr(3'd1, 8'd1);
        wr(3'd0, 8'd3);
        run(600);
        rd(3'd1, 8'd1, "R1");
        rd(3'd0, 8'd3, "R1");
        // mid-count rewrite
        wr(3'd1, 8'd0);
        wr(3'd0, 8'd9);
        run(4);
        wr(3'd0, 8'd4);
        run(15);
        // access bit off: neighbour addresses
        wr(3'd3, 8'h1B);
        chk("R3", int'(line_fmt), 8'h1B);
        wr(3'd0, 8'hAA);
        wr(3'd1, 8'h55);
        rd(3'd0, 8'h00, "R2");
        run(10);
        wr(3'd3, 8'h80);
        rd(3'd0, 8'd4, "R2");
        rd(3'd1, 8'd0, "R2");
        // zero divisor stops ticks
        wr(3'd0, 8'd0);
        run(50);
        wr(3'd0, 8'd3);
        run(12);
        // random divisors
        for (int k = 0; k < 12; k++) begin
            logic [7:0] d;
            d = 8'($urandom_range(1, 40));
            wr(3'd0, d);
            run(3 * int'(d) + 2);
            rd(3'd0, d, "R1");
        end
        // reset while running keeps latches, stops ticks
        wr(3'd0, 8'd6);
        run(7);
        do_reset();
        run(30);
        rd(3'd3, 8'h00, "R7");
        wr(3'd3, 8'h80);
        rd(3'd0, 8'd6, "R7");
        wr(3'd1, 8'd0);
        run(20);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule